// File: doc/BRIEF.md
# Mode-Coded Redundancy Interconnect

This block is a small switch network that sits between a group of three redundant compute modules with their majority voter and the system ports around them. A 2-bit mode code chooses one of four fixed routing patterns. In each of the three single-module patterns, one module receives the shared operand and the system output is taken from that module's result. This saves power but gives no fault tolerance. In the voting pattern, the shared operand is broadcast to all three modules and each module result is passed to the voter. The system output is then taken from the voter, so a single faulty module is outvoted.

The switch has five sources (`src0` to `src4`) and seven sinks (`dst1` to `dst7`), all of one parameterized width. Every bit of a port follows the same routing. A sink that the active pattern does not use is driven to zero. An optional output register, selected by a parameter, adds exactly one clock cycle of latency and resets to all zeros.

Top module: `mcri_switch`

## Requirements
- R1: With mode code 2'b00, dst1 carries src0 and dst7 carries src1, and all other sinks are zero.
- R2: With mode code 2'b01, dst2 carries src0 and dst7 carries src2, and all other sinks are zero.
- R3: With mode code 2'b10, dst3 carries src0 and dst7 carries src3, and all other sinks are zero.
- R4: With mode code 2'b11, src0 is copied to dst1, dst2 and dst3 together, and src1, src2, src3 and src4 drive dst4, dst5, dst6 and dst7 respectively.
- R5: dst7 always carries the source whose index is the mode code plus one (00 selects src1, 01 src2, 10 src3, 11 src4).
- R6: A source that the current mode does not route has no effect on any sink, and a sink that the mode does not use reads zero.
- R7: Every bit of a port is routed identically at the parameterized width DW, so arbitrary bit patterns pass through unchanged.
- R8: With REG_OUT=1, the sinks present the routing of the mode and sources sampled at the previous rising clock edge, which is exactly one cycle of latency.
- R9: With REG_OUT=1, all sinks read zero while rst_n is low and stay zero until the first rising edge after rst_n is released.
- R10: With REG_OUT=0, the sinks follow mode and source changes with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| mode_code | input | 2 | Routing pattern select: 00, 01 and 10 are single-module modes, 11 is the voting mode |
| src0 | input | DW | Shared operand destined for the compute modules |
| src1 | input | DW | Result of the first module |
| src2 | input | DW | Result of the second module |
| src3 | input | DW | Result of the third module |
| src4 | input | DW | Result of the voter |
| dst1 | output | DW | Operand to the first module |
| dst2 | output | DW | Operand to the second module |
| dst3 | output | DW | Operand to the third module |
| dst4 | output | DW | Voter input from the first module |
| dst5 | output | DW | Voter input from the second module |
| dst6 | output | DW | Voter input from the third module |
| dst7 | output | DW | System result |

## Verification
The hardest case to reach from the ports is a source that is silently ignored. In a single-module mode, src4 and two of the three module results are unused, and a routing fault that leaks them onto a sink stays invisible while those sources are zero or equal to the routed ones. The stimulus therefore holds the mode fixed and toggles only the unused sources to distinct nonzero patterns, and it requires every sink to stay put. Latency is probed by changing inputs just after a falling edge and sampling the registered sinks both before and after the next rising edge.

// File: rtl/mcri_pkg.sv
package mcri_pkg;

  localparam int NUM_MODES = 4;
  localparam int MODE_W    = $clog2(NUM_MODES);

  typedef enum logic [MODE_W-1:0] {
    MODE_SOLO_A = 2'd0,
    MODE_SOLO_B = 2'd1,
    MODE_SOLO_C = 2'd2,
    MODE_VOTE   = 2'd3
  } route_mode_e;

  localparam int VOTE_IX = int'(MODE_VOTE);

  // one-hot select for a mode code
  function automatic logic [NUM_MODES-1:0] mode_onehot(input logic [MODE_W-1:0] m);
    return NUM_MODES'(1) << m;
  endfunction

endpackage

// File: rtl/mcri_decode.sv
module mcri_decode
  import mcri_pkg::*;
(
  input  logic [MODE_W-1:0]    mode,
  output logic [NUM_MODES-1:0] sel
);

  assign sel = mode_onehot(mode);

endmodule

// File: rtl/mcri_lane_gate.sv
module mcri_lane_gate #(
  parameter int DW = 8
) (
  input  logic          en,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);

  assign dout = din & {DW{en}};

endmodule

// File: rtl/mcri_onehot_mux.sv
module mcri_onehot_mux #(
  parameter int DW = 8,
  parameter int N  = 4
) (
  input  logic [N-1:0]         sel,
  input  logic [N-1:0][DW-1:0] din,
  output logic [DW-1:0]        dout
);

  always_comb begin
    dout = '0;
    for (int i = 0; i < N; i++) begin
      dout = dout | (din[i] & {DW{sel[i]}});
    end
  end

endmodule

// File: rtl/mcri_out_stage.sv
module mcri_out_stage #(
  parameter int DW      = 8,
  parameter int NOUT    = 7,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NOUT-1:0][DW-1:0] d,
  output logic [NOUT-1:0][DW-1:0] q
);

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
      end
    end else begin : g_pass
      assign q = d;
    end
  endgenerate

endmodule

// File: rtl/mcri_switch.sv
module mcri_switch
  import mcri_pkg::*;
#(
  parameter int DW      = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_code,
  input  logic [DW-1:0]     src0,
  input  logic [DW-1:0]     src1,
  input  logic [DW-1:0]     src2,
  input  logic [DW-1:0]     src3,
  input  logic [DW-1:0]     src4,
  output logic [DW-1:0]     dst1,
  output logic [DW-1:0]     dst2,
  output logic [DW-1:0]     dst3,
  output logic [DW-1:0]     dst4,
  output logic [DW-1:0]     dst5,
  output logic [DW-1:0]     dst6,
  output logic [DW-1:0]     dst7
);

  localparam int NSHARE = NUM_MODES - 1;        // module operand sinks
  localparam int NSRC   = NSHARE + 2;           // operand + results + voter
  localparam int NDST   = 2 * NSHARE + 1;       // operands + voter inputs + result
  localparam int TAIL   = NDST - 1;

  logic [NUM_MODES-1:0]     route_sel;
  logic [NSRC-1:0][DW-1:0]  src_bus;
  logic [NDST-1:0][DW-1:0]  comb_bus;
  logic [NDST-1:0][DW-1:0]  out_bus;

  assign src_bus = {src4, src3, src2, src1, src0};

  mcri_decode u_dec (
    .mode (mode_code),
    .sel  (route_sel)
  );

  genvar k;
  generate
    // operand fan-out: own module in solo mode, all modules when voting
    for (k = 0; k < NSHARE; k++) begin : g_operand
      logic lane_en;
      assign lane_en = route_sel[k] | route_sel[VOTE_IX];
      mcri_lane_gate #(.DW(DW)) u_gate (
        .en   (lane_en),
        .din  (src_bus[0]),
        .dout (comb_bus[k])
      );
    end
    // module results towards the voter, only in voting mode
    for (k = 0; k < NSHARE; k++) begin : g_voter_in
      mcri_lane_gate #(.DW(DW)) u_gate (
        .en   (route_sel[VOTE_IX]),
        .din  (src_bus[k+1]),
        .dout (comb_bus[NSHARE+k])
      );
    end
  endgenerate

  // system result: source index = mode + 1
  mcri_onehot_mux #(.DW(DW), .N(NUM_MODES)) u_tail (
    .sel  (route_sel),
    .din  (src_bus[NSRC-1:1]),
    .dout (comb_bus[TAIL])
  );

  mcri_out_stage #(.DW(DW), .NOUT(NDST), .REG_OUT(REG_OUT)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (comb_bus),
    .q     (out_bus)
  );

  assign dst1 = out_bus[0];
  assign dst2 = out_bus[1];
  assign dst3 = out_bus[2];
  assign dst4 = out_bus[3];
  assign dst5 = out_bus[4];
  assign dst6 = out_bus[5];
  assign dst7 = out_bus[6];

endmodule

// File: rtl/mcri_switch_chk.sv
module mcri_switch_chk #(
  parameter int DW      = 8,
  parameter bit REG_OUT = 1'b1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    mode_code,
  input logic [DW-1:0] src0,
  input logic [DW-1:0] src1,
  input logic [DW-1:0] src2,
  input logic [DW-1:0] src3,
  input logic [DW-1:0] src4,
  input logic [DW-1:0] dst1,
  input logic [DW-1:0] dst2,
  input logic [DW-1:0] dst3,
  input logic [DW-1:0] dst4,
  input logic [DW-1:0] dst5,
  input logic [DW-1:0] dst6,
  input logic [DW-1:0] dst7,
  input logic [3:0]    route_sel
);

  // one-cycle history of the inputs, used when the outputs are registered
  logic          seen;
  logic [1:0]    pm;
  logic [DW-1:0] ps0, ps1, ps2, ps3, ps4;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen <= 1'b0;
      pm   <= '0;
      ps0  <= '0; ps1 <= '0; ps2 <= '0; ps3 <= '0; ps4 <= '0;
    end else begin
      seen <= 1'b1;
      pm   <= mode_code;
      ps0  <= src0; ps1 <= src1; ps2 <= src2; ps3 <= src3; ps4 <= src4;
    end
  end

  logic          armed;
  logic [1:0]    em;
  logic [DW-1:0] e0, e1, e2, e3, e4, etail;

  assign armed = REG_OUT ? seen : 1'b1;
  assign em    = REG_OUT ? pm   : mode_code;
  assign e0    = REG_OUT ? ps0  : src0;
  assign e1    = REG_OUT ? ps1  : src1;
  assign e2    = REG_OUT ? ps2  : src2;
  assign e3    = REG_OUT ? ps3  : src3;
  assign e4    = REG_OUT ? ps4  : src4;
  assign etail = (em == 2'd0) ? e1 : (em == 2'd1) ? e2 : (em == 2'd2) ? e3 : e4;

  p_solo_a_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && em == 2'd0) |-> (dst1 == e0 && dst2 == '0 && dst3 == '0 && dst7 == e1));

  p_solo_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && em == 2'd1) |-> (dst2 == e0 && dst1 == '0 && dst3 == '0 && dst7 == e2));

  p_solo_c_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && em == 2'd2) |-> (dst3 == e0 && dst1 == '0 && dst2 == '0 && dst7 == e3));

  p_vote_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && em == 2'd3) |-> (dst1 == e0 && dst2 == e0 && dst3 == e0 &&
                               dst4 == e1 && dst5 == e2 && dst6 == e3 && dst7 == e4));

  p_tail_pick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> dst7 == etail);

  p_sel_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(route_sel) == 1);

  p_voter_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && em != 2'd3) |-> (dst4 == '0 && dst5 == '0 && dst6 == '0));

  p_reset_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (dst1 == '0 && dst2 == '0 && dst3 == '0 && dst4 == '0 &&
                dst5 == '0 && dst6 == '0 && dst7 == '0));

endmodule

bind mcri_switch mcri_switch_chk #(.DW(DW), .REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/mcri_switch_test.sv
`timescale 1ns/1ps
module mcri_switch_test;

  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    mode = 2'd0;
  logic [DW-1:0] s0 = '0, s1 = '0, s2 = '0, s3 = '0, s4 = '0;

  logic [DW-1:0] r1, r2, r3, r4, r5, r6, r7;
  logic [DW-1:0] c1, c2, c3, c4, c5, c6, c7;

  int checks = 0;
  int fails  = 0;
  logic [6:0][DW-1:0] last_exp;

  always #2.5 clk = ~clk;

  mcri_switch #(.DW(DW), .REG_OUT(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .mode_code(mode),
    .src0(s0), .src1(s1), .src2(s2), .src3(s3), .src4(s4),
    .dst1(r1), .dst2(r2), .dst3(r3), .dst4(r4), .dst5(r5), .dst6(r6), .dst7(r7));

  mcri_switch #(.DW(DW), .REG_OUT(1'b0)) uut_comb (
    .clk(clk), .rst_n(rst_n), .mode_code(mode),
    .src0(s0), .src1(s1), .src2(s2), .src3(s3), .src4(s4),
    .dst1(c1), .dst2(c2), .dst3(c3), .dst4(c4), .dst5(c5), .dst6(c6), .dst7(c7));

  // routing table written from the requirements; index k is dst(k+1)
  function automatic logic [6:0][DW-1:0] model(input logic [1:0] m,
      input logic [DW-1:0] a0, a1, a2, a3, a4);
    logic [6:0][DW-1:0] r;
    r = '0;
    case (m)
      2'd0: begin r[0] = a0; r[6] = a1; end
      2'd1: begin r[1] = a0; r[6] = a2; end
      2'd2: begin r[2] = a0; r[6] = a3; end
      default: begin
        r[0] = a0; r[1] = a0; r[2] = a0;
        r[3] = a1; r[4] = a2; r[5] = a3; r[6] = a4;
      end
    endcase
    return r;
  endfunction

  function automatic logic [6:0][DW-1:0] reg_out();
    return {r7, r6, r5, r4, r3, r2, r1};
  endfunction

  function automatic logic [6:0][DW-1:0] comb_out();
    return {c7, c6, c5, c4, c3, c2, c1};
  endfunction

  task automatic check(input string tag, input logic [6:0][DW-1:0] got,
                       input logic [6:0][DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // drive after a falling edge, check combinational copy, then registered copy
  task automatic step(input string tag, input logic [1:0] m,
      input logic [DW-1:0] a0, a1, a2, a3, a4);
    logic [6:0][DW-1:0] e;
    @(negedge clk);
    mode = m; s0 = a0; s1 = a1; s2 = a2; s3 = a3; s4 = a4;
    e = model(m, a0, a1, a2, a3, a4);
    #1 check({tag, " comb"}, comb_out(), e);
    @(posedge clk);
    #1 check({tag, " reg"}, reg_out(), e);
    last_exp = e;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    mode = 2'd3; s0 = 8'h11; s1 = 8'h22; s2 = 8'h33; s3 = 8'h44; s4 = 8'h55;
    repeat (3) @(posedge clk);
    #1 check("R9 in reset", reg_out(), '0);
    @(negedge clk);
    rst_n = 1'b1;
    #1 check("R9 after release before edge", reg_out(), '0);
    @(posedge clk);
    #1 check("R9 first load", reg_out(), model(2'd3, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55));
  endtask

  task automatic t_solo();
    step("R1", 2'd0, 8'h3C, 8'hA1, 8'hB2, 8'hC3, 8'hD4);
    step("R1", 2'd0, 8'hFF, 8'h01, 8'h80, 8'h7F, 8'hFE);
    step("R2", 2'd1, 8'h3C, 8'hA1, 8'hB2, 8'hC3, 8'hD4);
    step("R2", 2'd1, 8'h5A, 8'h00, 8'hE7, 8'h18, 8'h99);
    step("R3", 2'd2, 8'h3C, 8'hA1, 8'hB2, 8'hC3, 8'hD4);
    step("R3", 2'd2, 8'h69, 8'h96, 8'h0F, 8'hF0, 8'h42);
  endtask

  task automatic t_vote();
    step("R4", 2'd3, 8'h3C, 8'hA1, 8'hB2, 8'hC3, 8'hD4);
    step("R4", 2'd3, 8'h00, 8'hFF, 8'h00, 8'hFF, 8'h5A);
  endtask

  task automatic t_tail();
    for (int m = 0; m < 4; m++) begin
      step("R5", 2'(m), 8'h10, 8'h21, 8'h32, 8'h43, 8'h54);
      check("R5 tail", {8'h0, 48'h0} | {c7, 48'h0}, {8'(8'h21 + 8'h11 * m), 48'h0});
    end
  endtask

  task automatic t_ignore();
    logic [6:0][DW-1:0] held;
    step("R6 base", 2'd0, 8'h77, 8'h88, 8'h00, 8'h00, 8'h00);
    held = model(2'd0, 8'h77, 8'h88, 8'h00, 8'h00, 8'h00);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      s2 = 8'hA5 ^ 8'(i); s3 = 8'h5A + 8'(i); s4 = 8'hC3 - 8'(i);
      #1 check("R6 unused sources comb", comb_out(), held);
      @(posedge clk);
      #1 check("R6 unused sources reg", reg_out(), held);
    end
  endtask

  task automatic t_bits();
    for (int b = 0; b < DW; b++) begin
      step("R7", 2'd3, 8'(1 << b), ~8'(1 << b), 8'(1 << b), ~8'(1 << b), 8'(1 << b));
    end
  endtask

  task automatic t_latency();
    logic [6:0][DW-1:0] e;
    step("R8 prior", 2'd1, 8'h12, 8'h34, 8'h56, 8'h78, 8'h9A);
    @(negedge clk);
    mode = 2'd3; s0 = 8'hE1; s1 = 8'hE2; s2 = 8'hE3; s3 = 8'hE4; s4 = 8'hE5;
    e = model(2'd3, 8'hE1, 8'hE2, 8'hE3, 8'hE4, 8'hE5);
    #1 check("R10 immediate", comb_out(), e);
    check("R8 holds before edge", reg_out(), last_exp);
    @(posedge clk);
    #1 check("R8 one cycle later", reg_out(), e);
  endtask

  initial begin : watchdog
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin : main
    t_reset();
    t_solo();
    t_vote();
    t_tail();
    t_ignore();
    t_bits();
    t_latency();
    repeat (2) @(posedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule